// File: doc/BRIEF.md
# Lane test pattern generator

This block drives one lane of a serial link that carries 10-bit symbols. Each clock it emits one word with a valid flag. A 3-bit mode input chooses where that word comes from. It can forward the lane's normal traffic, run one of two pseudo-random bit sequences, or repeat a short DC-balanced pattern built from a programmable 10-bit word and its bitwise inverse. Each lane has its own instance, so each lane enters test mode on its own. While a test runs, the lane's traffic input is ignored. The block adds no framing or word alignment, so the pattern runs back to back across words.

The controller is a small state machine whose state is decoded from the mode input every clock:

- `ST_PASS`: mode 0, traffic forwarded.
- `ST_PRBS7`: mode 1.
- `ST_PRBS31`: mode 2.
- `ST_FIX2`: mode 4.
- `ST_FIX4`: mode 5.
- `ST_BAD`: modes 3, 6 and 7. Traffic is forwarded and a flag is raised.

Every clock is a word boundary. A transition between two different states is a *restart*: the fixed-pattern index returns to 0, the pseudo-random register is reseeded, and the inversion phase is cleared. Staying in the same state is a *continue*: the sequence carries on from where it was. The output register adds one cycle of latency. Inputs sampled at a clock edge appear on the outputs just after that edge.

Top module: `lane_patgen`

## Requirements
- R1: While `rst_n` is low, `out_data_o` is 0, `out_valid_o` is 0 and `bad_mode_o` is 0.
- R2: With mode 0, after each edge `out_data_o` and `out_valid_o` equal the `tx_data_i` and `tx_valid_i` sampled at that edge, and `bad_mode_o` is 0.
- R3: In modes 1, 2, 4 and 5, `out_valid_o` is 1 and `tx_data_i` and `tx_valid_i` have no effect on the outputs.
- R4: Mode 4 repeats two words, `pat_word_i` and then `~pat_word_i`. The first word after entry is `pat_word_i`. Each word uses the `pat_word_i` sampled at the edge that produces it.
- R5: Mode 5 repeats four words: 0x000, `pat_word_i`, 0x3FF, `~pat_word_i`. The first word after entry is 0x000.
- R6: Mode 1 produces the sequence x^7+x^6+1. It runs on a 7-bit register `s` that is seeded to 0x7F. Each step computes `b = s[6]^s[5]` and then `s = {s[5:0], b}`. Ten steps make one word, and the first `b` of a word lands in bit 9.
- R7: Mode 2 produces the sequence x^31+x^28+1 in the same way as R6. It uses a 31-bit register seeded to 0x7FFFFFFF, and each step computes `b = s[30]^s[27]`.
- R8: In modes 1 and 2, every second word is sent bitwise inverted. The first word after entry is not inverted.
- R9: Modes 3, 6 and 7 behave like mode 0 and also set `bad_mode_o` to 1. In every other mode `bad_mode_o` is 0.
- R10: A new mode takes effect on the next word. A change to a different state restarts the new state's sequence, including a switch between modes 1 and 2. Holding the mode continues the sequence.
- R11: In modes 1 and 2 the pseudo-random register never holds all zeros. If it ever did, it would be reseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Source select (encoding in R2 to R9) |
| pat_word_i | input | 10 | Programmable word for the fixed patterns |
| tx_data_i | input | 10 | Normal traffic word |
| tx_valid_i | input | 1 | Normal traffic valid |
| out_data_o | output | 10 | Word sent toward the serializer |
| out_valid_o | output | 1 | Output word valid |
| bad_mode_o | output | 1 | Reserved mode selected |

## Verification
Two things can fall in the same cycle: a restart caused by a mode change, and the normal advance of a sequence. At that edge the block must drop the old index, seed and phase and emit the first word of the new sequence. It must not emit the next word of the old one. The bench provokes this in several ways. It switches directly between the two pseudo-random modes and between the two fixed modes. It also runs a long phase in which the mode changes at random on roughly a third of the clocks, often on consecutive clocks, while the pattern word and the traffic also change. A behavioural model in the bench computes the expected word from the mode sequence alone, and every clock's output is compared against it. Any restart that is missed or applied late shows up as a wrong word at that cycle.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_PASS   = 3'd0,
        ST_PRBS7  = 3'd1,
        ST_PRBS31 = 3'd2,
        ST_FIX2   = 3'd3,
        ST_FIX4   = 3'd4,
        ST_BAD    = 3'd5
    } lpg_state_e;

    function automatic lpg_state_e lpg_decode(input logic [MODE_W-1:0] m);
        lpg_state_e s;
        unique case (m)
            3'd0:    s = ST_PASS;
            3'd1:    s = ST_PRBS7;
            3'd2:    s = ST_PRBS31;
            3'd4:    s = ST_FIX2;
            3'd5:    s = ST_FIX4;
            default: s = ST_BAD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lpg_fixed_seq.sv
module lpg_fixed_seq #(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             four,
    input  logic             restart,
    input  logic [SYM_W-1:0] pat,
    output logic [SYM_W-1:0] word_o
);
    localparam int IDX_W = 2;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_eff;

    assign idx_eff = restart ? '0 : idx_q;

    always_comb begin
        if (four) begin
            unique case (idx_eff)
                2'd0: word_o = '0;
                2'd1: word_o = pat;
                2'd2: word_o = '1;
                2'd3: word_o = ~pat;
            endcase
        end else begin
            word_o = idx_eff[0] ? ~pat : pat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (active) begin
            idx_q <= idx_eff + 1'b1;
        end
    end

endmodule

// File: rtl/lpg_prbs_gen.sv
module lpg_prbs_gen #(
    parameter int SYM_W     = 10,
    parameter int LFSR_W    = 31,
    parameter int SHORT_LEN = 7,
    parameter int SHORT_TAP = 6,
    parameter int LONG_TAP  = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             wide,
    input  logic             restart,
    output logic [SYM_W-1:0] word_o
);
    localparam logic [LFSR_W-1:0] MASK_S = LFSR_W'((64'd1 << SHORT_LEN) - 1);
    localparam logic [LFSR_W-1:0] MASK_L = '1;

    logic [LFSR_W-1:0] lfsr_q, mask, cur, eff, nxt;
    logic [SYM_W-1:0]  raw;
    logic              inv_q, inv_eff;

    assign mask    = wide ? MASK_L : MASK_S;
    assign cur     = lfsr_q & mask;
    assign eff     = (restart || cur == '0) ? mask : cur;
    assign inv_eff = restart ? 1'b0 : inv_q;

    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              fb;
        s   = eff;
        raw = '0;
        for (int i = 0; i < SYM_W; i++) begin
            fb = wide ? (s[LFSR_W-1] ^ s[LONG_TAP-1])
                      : (s[SHORT_LEN-1] ^ s[SHORT_TAP-1]);
            s = {s[LFSR_W-2:0], fb} & mask;
            raw[SYM_W-1-i] = fb;
        end
        nxt = s;
    end

    assign word_o = raw ^ {SYM_W{inv_eff}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '0;
            inv_q  <= 1'b0;
        end else if (active) begin
            lfsr_q <= nxt;
            inv_q  <= ~inv_eff;
        end
    end

    assert_gen_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ((lfsr_q & $past(mask)) != '0));

    assert_phase_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart) |=> (inv_q != $past(inv_q)));

endmodule

// File: rtl/lane_patgen.sv
module lane_patgen
    import lpg_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic [SYM_W-1:0] pat_word_i,
    input  logic [SYM_W-1:0] tx_data_i,
    input  logic             tx_valid_i,
    output logic [SYM_W-1:0] out_data_o,
    output logic             out_valid_o,
    output logic             bad_mode_o
);
    lpg_state_e       state_q, ns;
    logic             restart;
    logic [SYM_W-1:0] prbs_word, fix_word;

    assign ns      = lpg_decode(mode_i);
    assign restart = (ns != state_q);

    lpg_prbs_gen #(.SYM_W(SYM_W)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (ns == ST_PRBS7 || ns == ST_PRBS31),
        .wide    (ns == ST_PRBS31),
        .restart (restart),
        .word_o  (prbs_word)
    );

    lpg_fixed_seq #(.SYM_W(SYM_W)) u_fix (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (ns == ST_FIX2 || ns == ST_FIX4),
        .four    (ns == ST_FIX4),
        .restart (restart),
        .pat     (pat_word_i),
        .word_o  (fix_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= ns;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data_o  <= '0;
            out_valid_o <= 1'b0;
            bad_mode_o  <= 1'b0;
        end else begin
            unique case (ns)
                ST_PASS, ST_BAD: begin
                    out_data_o  <= tx_data_i;
                    out_valid_o <= tx_valid_i;
                end
                ST_PRBS7, ST_PRBS31: begin
                    out_data_o  <= prbs_word;
                    out_valid_o <= 1'b1;
                end
                ST_FIX2, ST_FIX4: begin
                    out_data_o  <= fix_word;
                    out_valid_o <= 1'b1;
                end
                default: begin
                    out_data_o  <= tx_data_i;
                    out_valid_o <= tx_valid_i;
                end
            endcase
            bad_mode_o <= (ns == ST_BAD);
        end
    end

    assert_test_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_PRBS7, ST_PRBS31, ST_FIX2, ST_FIX4}) |-> out_valid_o);

    assert_bad_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode_o |-> (out_data_o == $past(tx_data_i) && out_valid_o == $past(tx_valid_i)));

    assert_fix2_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX2 && $past(state_q) == ST_FIX2 &&
         $past(pat_word_i) == $past(pat_word_i, 2)) |-> (out_data_o == ~$past(out_data_o)));

    assert_fix4_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX4 && $past(state_q) != ST_FIX4) |-> (out_data_o == '0));

endmodule

// File: tb/tb_lane_patgen.sv
`timescale 1ns/1ps
module tb_lane_patgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [9:0] pat = 10'h000;
    logic [9:0] txd = 10'h000;
    logic       txv = 1'b0;
    logic [9:0] out_data;
    logic       out_valid, bad_mode;

    lane_patgen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .pat_word_i (pat),
        .tx_data_i  (txd),
        .tx_valid_i (txv),
        .out_data_o (out_data),
        .out_valid_o(out_valid),
        .bad_mode_o (bad_mode)
    );

    always #2.5 clk = ~clk;

    int          vectors = 0;
    int          errors  = 0;
    bit          done    = 0;
    int          m_kind  = 0;
    int          m_idx   = 0;
    bit          m_inv   = 0;
    logic [30:0] m_lfsr  = '0;
    logic [9:0]  e_data;
    bit          e_valid, e_bad;
    string       e_tag;

    function automatic int kind_of(input logic [2:0] m);
        case (m)
            3'd0: return 0;
            3'd1: return 1;
            3'd2: return 2;
            3'd4: return 4;
            3'd5: return 5;
            default: return 3;
        endcase
    endfunction

    task automatic model();
        int          k   = kind_of(mode);
        bit          chg = (k != m_kind);
        logic [30:0] mask, s;
        logic [9:0]  w;
        bit          inv, fb;
        int          idx;
        e_bad = (k == 3);
        case (k)
            0, 3: begin
                e_data  = txd;
                e_valid = txv;
                e_tag   = (k == 0) ? "R2" : "R9";
            end
            4, 5: begin
                idx = chg ? 0 : m_idx;
                if (k == 4) begin
                    e_data = (idx % 2 == 0) ? pat : ~pat;
                    e_tag  = "R4 R3";
                end else begin
                    case (idx % 4)
                        0: e_data = 10'h000;
                        1: e_data = pat;
                        2: e_data = 10'h3FF;
                        default: e_data = ~pat;
                    endcase
                    e_tag = "R5 R3";
                end
                m_idx   = (idx + 1) % 4;
                e_valid = 1'b1;
            end
            default: begin
                mask = (k == 1) ? 31'h0000_007F : 31'h7FFF_FFFF;
                s    = m_lfsr & mask;
                if (chg || s == '0) s = mask;
                inv  = chg ? 1'b0 : m_inv;
                for (int i = 0; i < 10; i++) begin
                    fb = (k == 1) ? (s[6] ^ s[5]) : (s[30] ^ s[27]);
                    s  = {s[29:0], fb} & mask;
                    w[9-i] = fb;
                end
                e_data  = inv ? ~w : w;
                e_valid = 1'b1;
                m_lfsr  = s;
                m_inv   = ~inv;
                e_tag   = (k == 1) ? "R6 R8 R3" : "R7 R8 R3";
            end
        endcase
        if (chg) e_tag = {e_tag, " R10"};
        m_kind = k;
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (out_data !== e_data || out_valid !== e_valid || bad_mode !== e_bad) begin
            errors++;
            $display("FAIL %s: got data=%h valid=%b bad=%b expected data=%h valid=%b bad=%b",
                     tag, out_data, out_valid, bad_mode, e_data, e_valid, e_bad);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model();
        @(negedge clk);
        compare(e_tag);
    endtask

    task automatic run(input int n, input logic [2:0] m);
        for (int i = 0; i < n; i++) begin
            mode = m;
            txd  = 10'($urandom);
            txv  = 1'($urandom);
            tick();
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no end expected end within limit");
        finish_up();
    end

    initial begin
        mode = 3'd1; txd = 10'h2A5; txv = 1'b1; pat = 10'h155;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset even with active inputs
        e_data = '0; e_valid = 0; e_bad = 0;
        compare("R1");
        @(posedge clk);
        @(negedge clk);
        compare("R1");
        mode  = 3'd0;
        rst_n = 1'b1;
        run(20, 3'd0);               // R2
        pat = 10'h0F3;
        run(7, 3'd4);                // R4
        pat = 10'h301;
        run(6, 3'd4);                // R4 with new word
        run(9, 3'd5);                // R5, direct restart from mode 4
        run(3, 3'd4);                // R10 restart back
        run(300, 3'd1);              // R6 across the 127-bit period
        run(300, 3'd2);              // R7
        run(5, 3'd1);                // R10 switch between generators
        run(4, 3'd2);
        run(1, 3'd1);
        run(3, 3'd1);
        run(5, 3'd3);                // R9
        run(5, 3'd6);
        run(5, 3'd7);
        run(4, 3'd0);
        for (int i = 0; i < 2500; i++) begin
            if ($urandom_range(0, 2) == 0) mode = 3'($urandom);
            if ($urandom_range(0, 7) == 0) pat  = 10'($urandom);
            txd = 10'($urandom);
            txv = 1'($urandom);
            tick();
        end
        finish_up();
    end

endmodule